// File: doc/BRIEF.md
# Battery Capacity Ledger with Full-Charge Learning

This block keeps the charge-counting state of a battery gauge. Compensation logic upstream delivers single-cycle count pulses. A charge pulse adds one unit of charge. A discharge pulse removes one unit drawn by the load. A self-discharge pulse removes one unit of estimated internal leakage. The ledger turns these pulses into three 16-bit quantities:

- the available charge,
- the count drawn since the pack was last full,
- the learned full capacity, which is the 100% reference.

It also reports two status bits, one for a charge in progress and one for a discharge that still qualifies for learning. A third bit shows that the pack was replaced and has not yet been charged.

The block learns capacity as follows. A discharge that starts from full, runs without a qualified charge and reaches the first end-of-discharge threshold can be used as a measurement. On the next qualified charge, the count drawn becomes the new full reference. That update may lower the reference by at most a quarter of its old value. A charger "done" indication resynchronises the ledger to full. The empty threshold, the temperature flag, the charge-activity level and the programmed capacity all come from outside the block.

Top module: `capacity_ledger`

## Requirements
- R1: Available charge (`nac_o`) changes as follows. An effective charge pulse adds 1 but never takes it above `lmd_o`. An effective discharge or self-discharge pulse subtracts 1, with a floor of 0. At most one unit changes per cycle. A charge pulse and a discharge pulse in the same cycle cancel each other, and a self-discharge pulse in a cycle with an effective charge is dropped.
- R2: The drawn count (`dcr_o`) adds 1 on every effective discharge pulse. On a self-discharge-only cycle it adds 1 only while `nac_o` is above 0.
- R3: `dcr_o` saturates at 0xFFFF. In any cycle that starts with `nac_o` equal to `lmd_o`, the count restarts from 0 before that cycle's increment is applied.
- R4: With `done_i` high, on the next edge `nac_o` equals `lmd_o`, `vdq_o` is 1 and `dcr_o` is 0, whatever pulses arrive in that cycle. `lmd_o` is not updated in that cycle.
- R5: A run of charge pulses counts only while `chg_active_i` is high. The run restarts when `chg_active_i` is low or on an effective discharge pulse. `chgs_o` is 1 once the run holds at least 2 pulses. The third pulse of a run is the qualified ("valid") charge event, and every later pulse in the run is also qualified.
- R6: `vdq_o` sets on an effective discharge pulse in a cycle that starts with `nac_o` equal to `lmd_o`. It clears in any of these cases:
  - a valid charge event;
  - `edv1_i` and `cold_i` both high;
  - self-discharge counted since it was set exceeds `nac_o`/16.
  If a set and a clear fall in the same cycle, the set wins.
- R7: On a valid charge event, if the empty latch (R8) is held and `vdq_o` is 1, `lmd_o` becomes the larger of `dcr_o` and `lmd_o − lmd_o/4`, and `dcr_o` becomes 0.
- R8: A high `edv1_i` sets an internal empty latch. A valid charge event clears the latch. If the latch was held, that event also clears `nac_o` to 0.
- R9: Reset (synchronous, `rst_n` low) loads `lmd_o` from `pfc_i`, clears `nac_o`, `dcr_o`, `chgs_o` and `vdq_o`, and sets `brp_o` to 1.
- R10: `brp_o` clears in either of two cases: a qualified charge pulse leaves `nac_o` equal to `lmd_o`, or a valid charge event occurs while the empty latch is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pfc_i | input | 16 | Programmed full count, loaded into the capacity reference at reset |
| chg_pulse_i | input | 1 | One compensated charge unit |
| dis_pulse_i | input | 1 | One compensated discharge unit |
| sd_pulse_i | input | 1 | One self-discharge unit |
| chg_active_i | input | 1 | Charge current above the activity level |
| done_i | input | 1 | Charger reports full |
| edv1_i | input | 1 | First end-of-discharge threshold reached |
| cold_i | input | 1 | Temperature below 0 °C |
| nac_o | output | 16 | Available charge |
| dcr_o | output | 16 | Count drawn since full |
| lmd_o | output | 16 | Learned full capacity |
| chgs_o | output | 1 | Charge in progress |
| vdq_o | output | 1 | Discharge still qualifies for learning |
| brp_o | output | 1 | Pack replaced / reset and not yet charged full |

## Verification
The hardest situation to reach is a learning update. It needs this order of events:
1. A charger-done cycle.
2. Several hundred discharge pulses with no qualified charge between them.
3. An empty indication.
4. A charge run of exactly three pulses.

The stimulus runs this order twice. In the first pass the measured count lies above the 25% floor. In the second it lies below the floor, so the clamp is reached. Two further directed paths cover the cases where learning must be blocked: a cold empty indication, and enough self-discharge to drop `vdq_o`. Another run of tens of thousands of discharge pulses starting from an empty pack brings `dcr_o` to saturation. A pseudo-random phase mixes all inputs and covers same-cycle conflicts.

// File: rtl/cl_pkg.sv
package cl_pkg;
    localparam int CW = 16;

    typedef struct packed {
        logic [CW-1:0] nac;
        logic [CW-1:0] dcr;
        logic [CW-1:0] lmd;
        logic [CW-1:0] sdacc;
        logic          vdq;
        logic          brp;
        logic          empty_seen;
    } ledger_t;

    function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] v);
        return (v == {CW{1'b1}}) ? v : v + 1'b1;
    endfunction
endpackage

// File: rtl/cl_charge_qual.sv
module cl_charge_qual #(
    parameter int QUAL_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic chg_upd,
    input  logic dis_act,
    input  logic chg_active,
    output logic chgs_o,
    output logic qual_o,
    output logic first_o
);
    localparam int CNT_W = $clog2(QUAL_N + 2);
    localparam logic [CNT_W-1:0] TOP = CNT_W'(QUAL_N + 1);
    localparam logic [CNT_W-1:0] THR = CNT_W'(QUAL_N);

    logic [CNT_W-1:0] run_d, run_q;

    always_comb begin
        run_d = run_q;
        if (dis_act || !chg_active) begin
            run_d = '0;
        end else if (chg_upd && run_q < TOP) begin
            run_d = run_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
    end

    assign chgs_o  = run_q >= THR;
    assign qual_o  = chg_upd && chg_active && !dis_act && (run_q >= THR);
    assign first_o = chg_upd && chg_active && !dis_act && (run_q == THR);

    // R5: activity dropping clears the charge status next cycle
    p_chgs_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !chg_active |=> !chgs_o);
    // R5: the valid event leaves the status set
    p_first_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        first_o |=> chgs_o);
endmodule

// File: rtl/cl_learn_calc.sv
module cl_learn_calc #(
    parameter int W     = 16,
    parameter int SHIFT = 2
) (
    input  logic [W-1:0] lmd_i,
    input  logic [W-1:0] dcr_i,
    output logic [W-1:0] learned_o
);
    logic [W-1:0] floor_v;

    always_comb begin
        floor_v   = lmd_i - (lmd_i >> SHIFT);
        learned_o = (dcr_i > floor_v) ? dcr_i : floor_v;
    end
endmodule

// File: rtl/capacity_ledger.sv
module capacity_ledger
    import cl_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] pfc_i,
    input  logic          chg_pulse_i,
    input  logic          dis_pulse_i,
    input  logic          sd_pulse_i,
    input  logic          chg_active_i,
    input  logic          done_i,
    input  logic          edv1_i,
    input  logic          cold_i,
    output logic [CW-1:0] nac_o,
    output logic [CW-1:0] dcr_o,
    output logic [CW-1:0] lmd_o,
    output logic          chgs_o,
    output logic          vdq_o,
    output logic          brp_o
);
    localparam int SD_SHIFT = 4;

    ledger_t q, d;
    logic chg_e, dis_e, sd_e, sd_only, full, nz;
    logic qual, first, learn, vdq_set, vdq_clr, dcr_inc;
    logic [CW-1:0] learned, dcr_base;

    always_comb begin
        chg_e   = chg_pulse_i && !dis_pulse_i;
        dis_e   = dis_pulse_i && !chg_pulse_i;
        sd_e    = sd_pulse_i && !chg_e;
        sd_only = sd_e && !dis_e;
    end

    cl_charge_qual #(.QUAL_N(2)) u_qual (
        .clk        (clk),
        .rst_n      (rst_n),
        .chg_upd    (chg_e),
        .dis_act    (dis_e),
        .chg_active (chg_active_i),
        .chgs_o     (chgs_o),
        .qual_o     (qual),
        .first_o    (first)
    );

    cl_learn_calc #(.W(CW), .SHIFT(2)) u_learn (
        .lmd_i     (q.lmd),
        .dcr_i     (q.dcr),
        .learned_o (learned)
    );

    always_comb begin
        d       = q;
        full    = (q.nac == q.lmd);
        nz      = (q.nac != '0);
        learn   = first && q.empty_seen;

        // available charge
        if (chg_e && q.nac < q.lmd)      d.nac = q.nac + 1'b1;
        else if ((dis_e || sd_e) && nz)  d.nac = q.nac - 1'b1;
        if (learn)                       d.nac = '0;

        // drawn count
        dcr_base = full ? '0 : q.dcr;
        dcr_inc  = dis_e || (sd_only && nz);
        d.dcr    = dcr_inc ? sat_inc(dcr_base) : dcr_base;

        // self-discharge since qualification
        vdq_set = dis_e && full;
        vdq_clr = first || (edv1_i && cold_i)
                  || (q.vdq && (q.sdacc > (q.nac >> SD_SHIFT)));
        if (vdq_set)                     d.sdacc = '0;
        else if (sd_only && nz)          d.sdacc = sat_inc(q.sdacc);

        // learning transfer
        if (learn && q.vdq) begin
            d.lmd = learned;
            d.dcr = '0;
        end

        // empty latch
        if (first)       d.empty_seen = 1'b0;
        else if (edv1_i) d.empty_seen = 1'b1;

        // qualification flag
        if (vdq_clr) d.vdq = 1'b0;
        if (vdq_set) d.vdq = 1'b1;

        // charger done overrides
        if (done_i) begin
            d.nac   = q.lmd;
            d.dcr   = '0;
            d.lmd   = q.lmd;
            d.vdq   = 1'b1;
            d.sdacc = '0;
        end

        // replaced flag
        if (learn || (qual && d.nac == q.lmd)) d.brp = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.nac        <= '0;
            q.dcr        <= '0;
            q.lmd        <= pfc_i;
            q.sdacc      <= '0;
            q.vdq        <= 1'b0;
            q.brp        <= 1'b1;
            q.empty_seen <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign nac_o = q.nac;
    assign dcr_o = q.dcr;
    assign lmd_o = q.lmd;
    assign vdq_o = q.vdq;
    assign brp_o = q.brp;

    // R1: available charge never above the reference
    p_nac_cap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        q.nac <= q.lmd);
    // R3: saturated count holds unless cleared
    p_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.dcr == {CW{1'b1}} && !done_i && !full && !learn) |=> q.dcr == {CW{1'b1}});
    // R4: done forces full and qualified
    p_done_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> (q.nac == q.lmd) && q.vdq && (q.dcr == '0));
    // R7: reference never falls more than a quarter in one update
    p_lmd_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (learn && !done_i) |=> q.lmd >= ($past(q.lmd) - ($past(q.lmd) >> 2)));
    // R8: valid charge after empty zeroes available charge
    p_empty_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (learn && !done_i) |=> q.nac == '0);
    // R10: replaced flag never rises outside reset
    p_brp_fall_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !q.brp |=> !q.brp);
endmodule

// File: tb/tb_capacity_ledger.sv
`timescale 1ns/1ps
module tb_capacity_ledger;
    logic clk = 1'b0;
    logic rst_n;
    logic [15:0] pfc;
    logic chg, dis, sd, act, done, edv, cold;
    logic [15:0] nac_o, dcr_o, lmd_o;
    logic chgs_o, vdq_o, brp_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // reference state
    int m_nac, m_dcr, m_lmd, m_sd, m_cnt;
    bit m_vdq, m_brp, m_edv;

    always #10 clk = ~clk;

    capacity_ledger dut (
        .clk(clk), .rst_n(rst_n), .pfc_i(pfc),
        .chg_pulse_i(chg), .dis_pulse_i(dis), .sd_pulse_i(sd),
        .chg_active_i(act), .done_i(done), .edv1_i(edv), .cold_i(cold),
        .nac_o(nac_o), .dcr_o(dcr_o), .lmd_o(lmd_o),
        .chgs_o(chgs_o), .vdq_o(vdq_o), .brp_o(brp_o)
    );

    task automatic chk(input string tag, input int act_v, input int exp_v);
        n_cmp++;
        if (act_v != exp_v) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act_v, exp_v, $time);
        end
    endtask

    function automatic int inc16(input int v);
        return (v >= 65535) ? 65535 : v + 1;
    endfunction

    task automatic model_step();
        bit ce, de, se, so, full, nz, qual, first, learn, vset, vclr;
        int n_nac, n_dcr, n_lmd, n_sd, n_cnt, floor_v;
        bit n_vdq, n_brp, n_edv;
        if (!rst_n) begin
            m_nac = 0; m_dcr = 0; m_lmd = pfc; m_sd = 0; m_cnt = 0;
            m_vdq = 0; m_brp = 1; m_edv = 0;
            return;
        end
        ce = chg && !dis; de = dis && !chg; se = sd && !ce; so = se && !de;
        full = (m_nac == m_lmd); nz = (m_nac != 0);
        qual  = ce && act && !de && m_cnt >= 2;
        first = ce && act && !de && m_cnt == 2;
        learn = first && m_edv;
        n_cnt = (de || !act) ? 0 : ((ce && m_cnt < 3) ? m_cnt + 1 : m_cnt);
        n_nac = m_nac;
        if (ce && m_nac < m_lmd) n_nac = m_nac + 1;
        else if ((de || se) && nz) n_nac = m_nac - 1;
        if (learn) n_nac = 0;
        n_dcr = full ? 0 : m_dcr;
        if (de || (so && nz)) n_dcr = inc16(n_dcr);
        vset = de && full;
        vclr = first || (edv && cold) || (m_vdq && (m_sd > m_nac / 16));
        n_sd = m_sd;
        if (vset) n_sd = 0; else if (so && nz) n_sd = inc16(m_sd);
        n_lmd = m_lmd;
        if (learn && m_vdq) begin
            floor_v = m_lmd - m_lmd / 4;
            n_lmd = (m_dcr > floor_v) ? m_dcr : floor_v;
            n_dcr = 0;
        end
        n_edv = first ? 0 : (m_edv || edv);
        n_vdq = m_vdq;
        if (vclr) n_vdq = 0;
        if (vset) n_vdq = 1;
        if (done) begin
            n_nac = m_lmd; n_dcr = 0; n_lmd = m_lmd; n_vdq = 1; n_sd = 0;
        end
        n_brp = m_brp;
        if (learn || (qual && n_nac == m_lmd)) n_brp = 0;
        m_nac = n_nac; m_dcr = n_dcr; m_lmd = n_lmd; m_sd = n_sd; m_cnt = n_cnt;
        m_vdq = n_vdq; m_brp = n_brp; m_edv = n_edv;
    endtask

    // one clock: model consumes current inputs, outputs compared after the edge
    task automatic tick();
        model_step();
        @(negedge clk);
        chk("R1 nac", nac_o, m_nac);
        chk("R2/R3 dcr", dcr_o, m_dcr);
        chk("R7 lmd", lmd_o, m_lmd);
        chk("R5 chgs", chgs_o, (m_cnt >= 2) ? 1 : 0);
        chk("R6 vdq", vdq_o, m_vdq);
        chk("R10 brp", brp_o, m_brp);
    endtask

    task automatic idle();
        chg = 0; dis = 0; sd = 0; act = 0; done = 0; edv = 0; cold = 0;
    endtask

    task automatic run(input int n, input bit c, input bit d_, input bit s, input bit a);
        for (int i = 0; i < n; i++) begin
            idle(); chg = c; dis = d_; sd = s; act = a; tick();
        end
        idle();
    endtask

    task automatic do_reset(input int p);
        idle(); pfc = p[15:0]; rst_n = 0;
        for (int i = 0; i < 3; i++) tick();
        rst_n = 1;
    endtask

    task automatic pulse_done();
        idle(); done = 1; tick(); idle();
    endtask

    task automatic pulse_edv(input bit c);
        idle(); edv = 1; cold = c; tick(); idle();
    endtask

    initial begin
        int keep;
        logic [15:0] lf;
        do_reset(1000);
        // R9: reset values
        chk("R9 nac", nac_o, 0); chk("R9 lmd", lmd_o, 1000);
        chk("R9 vdq", vdq_o, 0); chk("R9 brp", brp_o, 1);

        run(5, 1, 0, 0, 1);
        chk("R5 chgs after run", chgs_o, 1);
        chk("R1 nac after charge", nac_o, 5);
        pulse_done();
        chk("R4 nac=lmd", nac_o, 1000); chk("R4 vdq", vdq_o, 1);
        run(3, 1, 0, 0, 1);
        chk("R1 nac capped", nac_o, 1000);

        run(900, 0, 1, 0, 0);
        chk("R6 vdq set", vdq_o, 1);
        chk("R2 dcr count", dcr_o, 900);
        run(2, 1, 1, 0, 1);
        chk("R1 cancel nac", nac_o, 100);
        chk("R5 cancel keeps run zero", chgs_o, 0);

        pulse_edv(0);
        run(3, 1, 0, 0, 1);
        chk("R7 learned", lmd_o, 900);
        chk("R8 nac cleared", nac_o, 0);
        chk("R10 brp cleared", brp_o, 0);

        pulse_done();
        run(300, 0, 1, 0, 0);
        pulse_edv(0);
        run(3, 1, 0, 0, 1);
        chk("R7 floor clamp", lmd_o, 675);

        pulse_done();
        run(60, 0, 0, 1, 0);
        chk("R6 vdq cleared by self-discharge", vdq_o, 0);
        chk("R2 sd counted", dcr_o, 60);

        run(700, 0, 1, 0, 0);
        keep = dcr_o;
        run(10, 0, 0, 1, 0);
        chk("R2 sd at empty ignored", dcr_o, keep);

        pulse_done();
        run(10, 0, 1, 0, 0);
        pulse_edv(1);
        chk("R6 cold clears vdq", vdq_o, 0);
        run(3, 1, 0, 0, 1);
        chk("R7 no learn when cold", lmd_o, 675);
        chk("R8 nac cleared cold", nac_o, 0);

        lf = 16'hACE1;
        for (int i = 0; i < 4000; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            chg = lf[0]; dis = lf[1] & lf[2]; sd = lf[3] & lf[4] & lf[5];
            act = lf[6] | lf[7]; done = (lf[15:8] == 8'h5A);
            edv = (lf[15:9] == 7'h33); cold = lf[8];
            tick();
        end

        do_reset(5);
        run(65540, 0, 1, 0, 0);
        chk("R3 dcr saturates", dcr_o, 65535);
        chk("R1 nac floor", nac_o, 0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #4000000;
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule